// File: doc/BRIEF.md
# Copy-Row Activate Selector

This block sits in a DRAM controller in front of the command scheduler. Each DRAM subarray holds a few spare copy rows next to its regular rows. The block keeps one table per subarray. The table records which regular row each copy row currently holds. A copy row holds either a cached duplicate of a recently opened regular row, or a permanent replacement for a regular row that a profiler has flagged as weak.

For every activate request the block looks up the addressed subarray and picks one of four activate flavours:

- a copy activate, which opens the regular row and then a freshly allocated copy row, so that both hold the data;
- a two-row activate, which opens the regular row together with the copy row that already duplicates it, for faster sensing;
- a redirected activate, which opens only the copy row that replaces a weak row;
- a plain activate, used when no copy row is available.

A separate configuration port lets a profiler install or clear permanent replacements at any time, including at run time. The decision is registered and appears one clock after the request. A write to a cached row needs no special handling, because the two-row activate restores both rows together.

Top module: `copy_row_table`

## Requirements
- R1: After reset no command is reported (`cmd_valid`=0) and every table entry is empty, so the first request to any subarray yields a copy activate into copy slot 0.
- R2: The command code is 0 for a plain activate, 1 for a copy activate, 2 for a two-row activate and 3 for a redirected activate. On a miss in a subarray that has an empty non-replacement slot, the block reports code 1 with the lowest-numbered empty slot. That slot then caches the requested row.
- R3: A request for a row held in a cache slot of its subarray yields code 2 with that slot. The slot is marked most recently used.
- R4: A request for a row held in a replacement slot yields code 3 with that slot. This does not change the cache recency order.
- R5: On a miss with no empty non-replacement slot, the least recently used cache slot is overwritten and reported with code 1. Use means an allocation or a two-row hit.
- R6: A slot holding a permanent replacement is never chosen for cache allocation.
- R7: When every slot of a subarray is a replacement, a miss yields code 0 with slot field 0 and allocates nothing, so the same request misses again.
- R8: A configuration write in the same cycle as a lookup to the same subarray does not affect that lookup's decision. It is applied after the lookup's own allocation, and it wins if both target the same slot.
- R9: Installing a replacement for a row removes any cache slot in the same subarray that holds that row. Clearing a slot makes it empty and free for allocation.
- R10: Each subarray's table is independent: requests and configuration writes to one subarray never change decisions in another.
- R11: A command appears exactly one cycle after its request and carries the request's subarray and row. With no request, `cmd_valid` is 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Activate request strobe |
| req_sa | input | SA_W | Subarray of the request |
| req_row | input | ROW_W | Regular row of the request |
| cfg_valid | input | 1 | Configuration write strobe |
| cfg_sa | input | SA_W | Subarray being configured |
| cfg_slot | input | SLOT_W | Copy slot being configured |
| cfg_install | input | 1 | 1 installs a replacement, 0 clears the slot |
| cfg_row | input | ROW_W | Weak regular row replaced by the slot |
| cmd_valid | output | 1 | Decision strobe, one cycle after the request |
| cmd_kind | output | 2 | Activate flavour code (see R2) |
| cmd_sa | output | SA_W | Subarray of the decision |
| cmd_row | output | ROW_W | Regular row of the decision |
| cmd_slot | output | SLOT_W | Copy slot used by the decision |

## Verification
A directed opening drives a single subarray through each stage in turn: cold misses, a repeated hit, filling every slot and then evicting the oldest. It then covers replacement install and clear, a lookup that coincides with a configuration write, and a subarray made entirely of replacements. These steps separate first-empty allocation from least-recently-used eviction, and show whether replacement slots stay pinned.

A long pseudo-random sweep follows. It draws rows from a small pool across two subarrays, with configuration writes scattered in. A timestamp model in the bench predicts every code and slot. Because of the small pool, hits, evictions, replacements and coincident writes all recur many times in varied orders.

// File: rtl/crt_pkg.sv
package crt_pkg;
   // Activate flavour chosen for a request
   typedef enum logic [1:0] {
      CMD_ACT       = 2'd0,
      CMD_ACT_COPY  = 2'd1,
      CMD_ACT_TWO   = 2'd2,
      CMD_ACT_REMAP = 2'd3
   } crt_cmd_e;
endpackage

// File: rtl/crt_lookup.sv
module crt_lookup #(
   parameter int ENTRIES = 8,
   parameter int TAG_W   = 9,
   parameter int IDX_W   = 3
) (
   input  logic [ENTRIES-1:0]            ent_valid,
   input  logic [ENTRIES-1:0]            ent_remap,
   input  logic [ENTRIES-1:0][TAG_W-1:0] ent_tag,
   input  logic [TAG_W-1:0]              key,
   output logic [ENTRIES-1:0]            cache_hit,
   output logic [ENTRIES-1:0]            remap_hit,
   output logic                          cache_any,
   output logic                          remap_any,
   output logic [IDX_W-1:0]              cache_idx,
   output logic [IDX_W-1:0]              remap_idx
);
   // Per-entry tag comparators, split by entry role
   for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
      logic match;
      assign match        = ent_valid[g] && (ent_tag[g] == key);
      assign cache_hit[g] = match && !ent_remap[g];
      assign remap_hit[g] = match &&  ent_remap[g];
   end

   assign cache_any = |cache_hit;
   assign remap_any = |remap_hit;

   // Lowest index wins; scan from the top
   always_comb begin
      cache_idx = '0;
      remap_idx = '0;
      for (int k = ENTRIES - 1; k >= 0; k--) begin
         if (cache_hit[k]) cache_idx = IDX_W'(k);
         if (remap_hit[k]) remap_idx = IDX_W'(k);
      end
   end
endmodule

// File: rtl/crt_victim.sv
module crt_victim #(
   parameter int ENTRIES = 8,
   parameter int IDX_W   = 3
) (
   input  logic [ENTRIES-1:0]            ent_valid,
   input  logic [ENTRIES-1:0]            ent_remap,
   input  logic [ENTRIES-1:0][IDX_W-1:0] ent_age,
   output logic                          found,
   output logic [IDX_W-1:0]              idx
);
   logic             inv_found, old_found;
   logic [IDX_W-1:0] inv_idx, old_idx, best_age;

   always_comb begin
      inv_found = 1'b0;
      inv_idx   = '0;
      old_found = 1'b0;
      old_idx   = '0;
      best_age  = '0;
      for (int k = 0; k < ENTRIES; k++) begin
         // Replacement entries are pinned and never eligible
         if (!ent_remap[k]) begin
            if (!ent_valid[k]) begin
               if (!inv_found) begin
                  inv_found = 1'b1;
                  inv_idx   = IDX_W'(k);
               end
            end else if (!old_found || (ent_age[k] > best_age)) begin
               old_found = 1'b1;
               old_idx   = IDX_W'(k);
               best_age  = ent_age[k];
            end
         end
      end
      found = inv_found || old_found;
      idx   = inv_found ? inv_idx : old_idx;
   end
endmodule

// File: rtl/crt_bank.sv
module crt_bank
   import crt_pkg::*;
#(
   parameter int ENTRIES = 8,
   parameter int TAG_W   = 9,
   parameter int IDX_W   = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lk_en,
   input  logic [TAG_W-1:0] lk_key,
   input  logic             cfg_en,
   input  logic             cfg_install,
   input  logic [IDX_W-1:0] cfg_slot,
   input  logic [TAG_W-1:0] cfg_key,
   output crt_cmd_e         dec_kind,
   output logic [IDX_W-1:0] dec_slot
);
   logic [ENTRIES-1:0]            valid_q, valid_d;
   logic [ENTRIES-1:0]            remap_q, remap_d;
   logic [ENTRIES-1:0][TAG_W-1:0] tag_q,   tag_d;
   logic [ENTRIES-1:0][IDX_W-1:0] age_q,   age_d;

   logic [ENTRIES-1:0] cache_hit, remap_hit;
   logic               cache_any, remap_any, vic_found;
   logic [IDX_W-1:0]   cache_idx, remap_idx, vic_idx;
   logic               touch;

   crt_lookup #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_lookup (
      .ent_valid (valid_q),
      .ent_remap (remap_q),
      .ent_tag   (tag_q),
      .key       (lk_key),
      .cache_hit (cache_hit),
      .remap_hit (remap_hit),
      .cache_any (cache_any),
      .remap_any (remap_any),
      .cache_idx (cache_idx),
      .remap_idx (remap_idx)
   );

   crt_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_victim (
      .ent_valid (valid_q),
      .ent_remap (remap_q),
      .ent_age   (age_q),
      .found     (vic_found),
      .idx       (vic_idx)
   );

   // Decision from the table state before this cycle's updates
   always_comb begin
      if (remap_any) begin
         dec_kind = CMD_ACT_REMAP;
         dec_slot = remap_idx;
      end else if (cache_any) begin
         dec_kind = CMD_ACT_TWO;
         dec_slot = cache_idx;
      end else if (vic_found) begin
         dec_kind = CMD_ACT_COPY;
         dec_slot = vic_idx;
      end else begin
         dec_kind = CMD_ACT;
         dec_slot = '0;
      end
   end

   assign touch = lk_en && ((dec_kind == CMD_ACT_TWO) || (dec_kind == CMD_ACT_COPY));

   // Next state: lookup effects first, configuration layered on top
   always_comb begin
      valid_d = valid_q;
      remap_d = remap_q;
      tag_d   = tag_q;
      age_d   = age_q;
      if (lk_en && (dec_kind == CMD_ACT_COPY)) begin
         valid_d[dec_slot] = 1'b1;
         remap_d[dec_slot] = 1'b0;
         tag_d[dec_slot]   = lk_key;
      end
      if (touch) begin
         for (int k = 0; k < ENTRIES; k++) begin
            if (IDX_W'(k) == dec_slot)          age_d[k] = '0;
            else if (age_q[k] < age_q[dec_slot]) age_d[k] = age_q[k] + 1'b1;
         end
      end
      if (cfg_en) begin
         if (cfg_install) begin
            for (int k = 0; k < ENTRIES; k++) begin
               if (valid_d[k] && !remap_d[k] && (tag_d[k] == cfg_key)) valid_d[k] = 1'b0;
            end
            valid_d[cfg_slot] = 1'b1;
            remap_d[cfg_slot] = 1'b1;
            tag_d[cfg_slot]   = cfg_key;
         end else begin
            valid_d[cfg_slot] = 1'b0;
            remap_d[cfg_slot] = 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= '0;
         remap_q <= '0;
         tag_q   <= '0;
         for (int k = 0; k < ENTRIES; k++) age_q[k] <= IDX_W'(k);
      end else begin
         valid_q <= valid_d;
         remap_q <= remap_d;
         tag_q   <= tag_d;
         age_q   <= age_d;
      end
   end

   // Recency values must stay a permutation of slot numbers
   logic [ENTRIES-1:0] age_seen;
   always_comb begin
      age_seen = '0;
      for (int k = 0; k < ENTRIES; k++) age_seen[age_q[k]] = 1'b1;
   end

   AST_CACHE_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cache_hit)); // R3
   AST_VICTIM_NOT_PINNED: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_kind == CMD_ACT_COPY) |-> !remap_q[dec_slot]); // R6
   AST_PINNED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_en |=> $stable(remap_q)); // R6
   AST_ALLOC_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_en && (dec_kind == CMD_ACT_COPY) && !cfg_en) |=>
      (valid_q[$past(dec_slot)] && (tag_q[$past(dec_slot)] == $past(lk_key)))); // R2
   AST_AGE_PERMUTATION: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(age_seen) == ENTRIES); // R5
   AST_FULL_PINNED_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
      ((&remap_q) && !remap_any) |-> (dec_kind == CMD_ACT)); // R7
endmodule

// File: rtl/copy_row_table.sv
module copy_row_table
   import crt_pkg::*;
#(
   parameter int NUM_SUBARRAYS = 4,
   parameter int ROWS_PER_SA   = 512,
   parameter int COPY_ROWS     = 8,
   parameter int SA_W          = $clog2(NUM_SUBARRAYS),
   parameter int ROW_W         = $clog2(ROWS_PER_SA),
   parameter int SLOT_W        = $clog2(COPY_ROWS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [SA_W-1:0]   req_sa,
   input  logic [ROW_W-1:0]  req_row,
   input  logic              cfg_valid,
   input  logic [SA_W-1:0]   cfg_sa,
   input  logic [SLOT_W-1:0] cfg_slot,
   input  logic              cfg_install,
   input  logic [ROW_W-1:0]  cfg_row,
   output logic              cmd_valid,
   output logic [1:0]        cmd_kind,
   output logic [SA_W-1:0]   cmd_sa,
   output logic [ROW_W-1:0]  cmd_row,
   output logic [SLOT_W-1:0] cmd_slot
);
   // Elaboration-time parameter checks
   if (NUM_SUBARRAYS < 2 || (1 << SA_W) != NUM_SUBARRAYS) begin : g_bad_sa
      $error("NUM_SUBARRAYS must be a power of two, at least 2");
   end
   if (COPY_ROWS < 2 || (1 << SLOT_W) != COPY_ROWS) begin : g_bad_cr
      $error("COPY_ROWS must be a power of two, at least 2");
   end
   if (ROWS_PER_SA < 2 || (1 << ROW_W) != ROWS_PER_SA) begin : g_bad_rows
      $error("ROWS_PER_SA must be a power of two, at least 2");
   end

   crt_cmd_e          bank_kind [NUM_SUBARRAYS];
   logic [SLOT_W-1:0] bank_slot [NUM_SUBARRAYS];

   for (genvar i = 0; i < NUM_SUBARRAYS; i++) begin : g_bank
      crt_bank #(.ENTRIES(COPY_ROWS), .TAG_W(ROW_W), .IDX_W(SLOT_W)) u_bank (
         .clk         (clk),
         .rst_n       (rst_n),
         .lk_en       (req_valid && (req_sa == SA_W'(i))),
         .lk_key      (req_row),
         .cfg_en      (cfg_valid && (cfg_sa == SA_W'(i))),
         .cfg_install (cfg_install),
         .cfg_slot    (cfg_slot),
         .cfg_key     (cfg_row),
         .dec_kind    (bank_kind[i]),
         .dec_slot    (bank_slot[i])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_valid <= 1'b0;
         cmd_kind  <= CMD_ACT;
         cmd_sa    <= '0;
         cmd_row   <= '0;
         cmd_slot  <= '0;
      end else begin
         cmd_valid <= req_valid;
         if (req_valid) begin
            cmd_kind <= bank_kind[req_sa];
            cmd_slot <= bank_slot[req_sa];
            cmd_sa   <= req_sa;
            cmd_row  <= req_row;
         end
      end
   end

   AST_CMD_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> $past(req_valid)); // R11
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !cmd_valid); // R11
endmodule

// File: tb/copy_row_table_tb.sv
`timescale 1ns/1ps
module copy_row_table_tb;
   localparam int NSA = 2;
   localparam int NCR = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic [0:0] req_sa = '0;
   logic [8:0] req_row = '0;
   logic       cfg_valid = 1'b0;
   logic [0:0] cfg_sa = '0;
   logic [2:0] cfg_slot = '0;
   logic       cfg_install = 1'b0;
   logic [8:0] cfg_row = '0;
   logic       cmd_valid;
   logic [1:0] cmd_kind;
   logic [0:0] cmd_sa;
   logic [8:0] cmd_row;
   logic [2:0] cmd_slot;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   copy_row_table #(.NUM_SUBARRAYS(NSA), .ROWS_PER_SA(512), .COPY_ROWS(NCR)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_sa(req_sa), .req_row(req_row),
      .cfg_valid(cfg_valid), .cfg_sa(cfg_sa), .cfg_slot(cfg_slot),
      .cfg_install(cfg_install), .cfg_row(cfg_row),
      .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_sa(cmd_sa),
      .cmd_row(cmd_row), .cmd_slot(cmd_slot)
   );

   // Timestamp model of the table
   bit mv [NSA][NCR];
   bit mr [NSA][NCR];
   int mt [NSA][NCR];
   int ms [NSA][NCR];
   int now = 1;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic op(input bit rv, input int sa, input int row,
                     input bit cv, input int csa, input int cslot,
                     input bit cins, input int crow, input string tag);
      int ek = 0, es = 0;
      bit done_k = 1'b0, had_inv = 1'b0;
      string lbl;
      req_valid = rv; req_sa = 1'(sa); req_row = 9'(row);
      cfg_valid = cv; cfg_sa = 1'(csa); cfg_slot = 3'(cslot);
      cfg_install = cins; cfg_row = 9'(crow);
      if (rv) begin
         for (int k = 0; k < NCR; k++)
            if (!done_k && mv[sa][k] && mr[sa][k] && mt[sa][k] == row) begin
               done_k = 1'b1; ek = 3; es = k;
            end
         for (int k = 0; k < NCR; k++)
            if (!done_k && mv[sa][k] && !mr[sa][k] && mt[sa][k] == row) begin
               done_k = 1'b1; ek = 2; es = k; ms[sa][k] = now;
            end
         for (int k = 0; k < NCR; k++)
            if (!done_k && !mv[sa][k] && !mr[sa][k]) begin
               done_k = 1'b1; had_inv = 1'b1; ek = 1; es = k;
            end
         if (!done_k) begin
            int best = -1;
            for (int k = 0; k < NCR; k++)
               if (!mr[sa][k] && mv[sa][k] && (best < 0 || ms[sa][k] < ms[sa][best])) best = k;
            if (best >= 0) begin
               done_k = 1'b1; ek = 1; es = best;
            end
         end
         if (ek == 1) begin
            mv[sa][es] = 1'b1; mr[sa][es] = 1'b0; mt[sa][es] = row; ms[sa][es] = now;
         end
      end
      if (cv) begin
         if (cins) begin
            for (int k = 0; k < NCR; k++)
               if (mv[csa][k] && !mr[csa][k] && mt[csa][k] == crow) mv[csa][k] = 1'b0;
            mv[csa][cslot] = 1'b1; mr[csa][cslot] = 1'b1; mt[csa][cslot] = crow;
         end else begin
            mv[csa][cslot] = 1'b0; mr[csa][cslot] = 1'b0;
         end
      end
      now++;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0; cfg_valid = 1'b0;
      if (tag != "") lbl = tag;
      else case (ek)
         3: lbl = "R4";
         2: lbl = "R3";
         1: lbl = had_inv ? "R2" : "R5";
         default: lbl = "R7";
      endcase
      if (!rv) begin
         check(cmd_valid == 1'b0, "R11", "idle cmd_valid", int'(cmd_valid), 0);
      end else begin
         check(cmd_valid && cmd_sa == 1'(sa) && cmd_row == 9'(row), "R11", "echo row",
               int'(cmd_row), row);
         check(cmd_kind == 2'(ek) && cmd_slot == 3'(es), lbl, "kind*8+slot",
               int'(cmd_kind) * 8 + int'(cmd_slot), ek * 8 + es);
      end
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      check(cmd_valid == 1'b0, "R1", "reset cmd_valid", int'(cmd_valid), 0);
      // R1/R2: cold miss goes to slot 0, then a hit
      op(1, 0, 5, 0, 0, 0, 0, 0, "R1");
      op(1, 0, 5, 0, 0, 0, 0, 0, "R3");
      for (int r = 10; r < 17; r++) op(1, 0, r, 0, 0, 0, 0, 0, "R2");
      // R5: full table evicts least recently used
      op(1, 0, 20, 0, 0, 0, 0, 0, "R5");
      op(1, 0, 11, 0, 0, 0, 0, 0, "R3");
      op(1, 0, 21, 0, 0, 0, 0, 0, "R5");
      // R4/R6: install a replacement then miss repeatedly
      op(0, 0, 0, 1, 0, 3, 1, 100, "R11");
      op(1, 0, 100, 0, 0, 0, 0, 0, "R4");
      for (int r = 30; r < 40; r++) op(1, 0, r, 0, 0, 0, 0, 0, "R6");
      op(1, 0, 100, 0, 0, 0, 0, 0, "R4");
      // R9: install over a cached row, then clear a slot
      op(0, 0, 0, 1, 0, 6, 1, 39, "R11");
      op(1, 0, 39, 0, 0, 0, 0, 0, "R9");
      op(1, 0, 41, 0, 0, 0, 0, 0, "R9");
      op(0, 0, 0, 1, 0, 3, 0, 0, "R11");
      op(1, 0, 100, 0, 0, 0, 0, 0, "R9");
      // R8: coincident lookup and configuration write
      op(1, 0, 200, 1, 0, 1, 1, 200, "R8");
      op(1, 0, 200, 0, 0, 0, 0, 0, "R8");
      // R10: other subarray unaffected
      op(1, 1, 5, 0, 0, 0, 0, 0, "R10");
      op(1, 1, 5, 0, 0, 0, 0, 0, "R10");
      // R7: subarray of replacements only
      for (int k = 0; k < NCR; k++) op(0, 0, 0, 1, 1, k, 1, 300 + k, "R11");
      op(1, 1, 400, 0, 0, 0, 0, 0, "R7");
      op(1, 1, 400, 0, 0, 0, 0, 0, "R7");
      op(1, 1, 303, 0, 0, 0, 0, 0, "R4");
      op(1, 0, 300, 0, 0, 0, 0, 0, "R10");
      op(0, 0, 0, 0, 0, 0, 0, 0, "R11");
      // Sweep over a small row pool with scattered configuration
      for (int n = 0; n < 4000; n++) begin
         int rsa = int'($urandom_range(1, 0));
         int rrow = (int'($urandom_range(13, 0)) * 37) % 512;
         bit cv = ($urandom_range(9, 0) == 0);
         int csa = int'($urandom_range(1, 0));
         int cs = int'($urandom_range(7, 0));
         bit ci = ($urandom_range(2, 0) == 0);
         int crow = (int'($urandom_range(13, 0)) * 37) % 512;
         bit rv = ($urandom_range(15, 0) != 0);
         op(rv, rsa, rrow, cv, csa, cs, ci, crow, "");
      end
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule